// File: doc/BRIEF.md
# Traffic-Class Ordering Queue

This block holds a small pool of transaction headers and picks, every cycle, at most one of them to hand to a downstream port. Each header carries a 3-bit traffic class, a relaxed-ordering flag, a destination index and an opaque tag. Headers enter through a valid/ready push port and leave through a valid/ready pop port. One input bit per destination reports that the destination's receive buffer is full, and no header is issued towards a full destination.

The ordering rules apply only within one traffic class. By default a class drains strictly oldest-first. When the oldest header of a class cannot go because its destination is full, the oldest relaxed-ordering header of that class whose own destination has room is issued instead, and the blocked header keeps its place. A header without the relaxed flag never overtakes an older header of its own class. Classes share no ordering, so a stalled class never holds up another. When several classes can issue, a round-robin pointer over the eight classes picks one.

Top module: `tc_order_queue`

## Requirements
- R1: In the first cycle after synchronous reset, `pop_valid_o` is 0 and `push_ready_o` is 1, and the round-robin pointer starts at class 0.
- R2: `push_ready_o` is 0 exactly while DEPTH headers are held (DEPTH = 8 by default), and it is 1 again in the cycle after a pop that leaves room.
- R3: A header whose relaxed flag `push_ro_i` was 0 is issued only when it is the oldest header held for its class.
- R4: When the oldest header of a class has a destination that is not full, that header is the one the class offers, even when relaxed headers of the same class are waiting behind it.
- R5: When the oldest header of a class has a full destination, the class offers the oldest relaxed header behind it whose own destination is not full. The blocked oldest header stays held and is issued later in its turn.
- R6: No header is issued while bit `pop_dst_o` of `dst_full_i` is 1. `pop_valid_o` is 0 when no class has a header that can be issued.
- R7: A class whose headers are all blocked does not stop another class with a free destination from issuing in the same cycle.
- R8: Among the classes that can issue, the grant goes to the first one found counting upwards, with wrap-around, from the pointer. After each pop the pointer moves to the granted class plus one, modulo 8.
- R9: Once every destination is free and `pop_ready_i` is held high, every header that was pushed is popped exactly once. After that, `pop_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| push_valid_i | input | 1 | Header offered on the push side |
| push_tc_i | input | 3 | Traffic class of the offered header |
| push_ro_i | input | 1 | Relaxed-ordering flag of the offered header |
| push_dst_i | input | 2 | Destination index of the offered header |
| push_tag_i | input | 8 | Opaque tag of the offered header |
| push_ready_o | output | 1 | Queue can accept a header |
| pop_valid_o | output | 1 | A header is being issued |
| pop_ready_i | input | 1 | Downstream accepts the issued header |
| pop_tc_o | output | 3 | Traffic class of the issued header |
| pop_ro_o | output | 1 | Relaxed-ordering flag of the issued header |
| pop_dst_o | output | 2 | Destination index of the issued header |
| pop_tag_o | output | 8 | Tag of the issued header |
| dst_full_i | input | 4 | One bit per destination: receive buffer full |

## Verification
The hardest case to reach is a class whose oldest header is blocked while, behind it, a plain header sits next to two relaxed headers, one of them also blocked and one free. Only the free relaxed header may leave, and after it leaves the class must go quiet until the head's destination clears. Directed sequences load such a class while pop is held off, then open the pop side with a chosen destination mask. A long random phase follows, with the destination mask held for several cycles at a time so that stalls last long enough for relaxed headers to pile up behind blocked heads. A behavioural model compares the issue choice, tag and ready on every cycle.

// File: rtl/tc_order_pkg.sv
package tc_order_pkg;

    localparam int TC_W    = 3;
    localparam int NUM_TC  = 1 << TC_W;
    localparam int DST_W   = 2;
    localparam int NUM_DST = 1 << DST_W;
    localparam int TAG_W   = 8;

    typedef struct packed {
        logic [TC_W-1:0]  tc;
        logic             ro;
        logic [DST_W-1:0] dst;
        logic [TAG_W-1:0] tag;
    } hdr_t;

    // Pointer following a grant; wraps because NUM_TC is a power of two.
    function automatic logic [TC_W-1:0] rr_after(input logic [TC_W-1:0] granted);
        return granted + 1'b1;
    endfunction

endpackage

// File: rtl/tco_class_pick.sv
// Chooses the slot a single class offers: its oldest slot if that one is
// free to go, otherwise the oldest relaxed slot behind it that is free.
module tco_class_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] member_i,
    input  logic [DEPTH-1:0] relaxed_i,
    input  logic [DEPTH-1:0] stuck_i,
    output logic             has_o,
    output logic [IDX_W-1:0] idx_o
);
    logic seen_head;

    always_comb begin
        has_o     = 1'b0;
        idx_o     = '0;
        seen_head = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (member_i[i] && !has_o) begin
                if (!seen_head) begin
                    seen_head = 1'b1;
                    if (!stuck_i[i]) begin
                        has_o = 1'b1;
                        idx_o = IDX_W'(i);
                    end
                end else if (relaxed_i[i] && !stuck_i[i]) begin
                    has_o = 1'b1;
                    idx_o = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/tco_rr_arb.sv
// Round-robin pick across requesters, starting the search at ptr_i.
module tco_rr_arb #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    input  logic [W-1:0] ptr_i,
    output logic         gnt_valid_o,
    output logic [W-1:0] gnt_idx_o
);
    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr_i) + k) % N;
            if (!gnt_valid_o && req_i[j]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = W'(j);
            end
        end
    end

endmodule

// File: rtl/tc_order_queue.sv
module tc_order_queue
    import tc_order_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             push_valid_i,
    input  logic [TC_W-1:0]  push_tc_i,
    input  logic             push_ro_i,
    input  logic [DST_W-1:0] push_dst_i,
    input  logic [TAG_W-1:0] push_tag_i,
    output logic             push_ready_o,
    output logic             pop_valid_o,
    input  logic             pop_ready_i,
    output logic [TC_W-1:0]  pop_tc_o,
    output logic             pop_ro_o,
    output logic [DST_W-1:0] pop_dst_o,
    output logic [TAG_W-1:0] pop_tag_o,
    input  logic [NUM_DST-1:0] dst_full_i
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    // Slots are kept in arrival order: slot 0 is the oldest.
    hdr_t             slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [TC_W-1:0]  rr_q;

    logic [DEPTH-1:0] live, relaxed, stuck;
    logic [NUM_TC-1:0] cls_has;
    logic [IDX_W-1:0]  cls_idx [NUM_TC];
    logic              gnt_valid;
    logic [TC_W-1:0]   gnt_cls;
    logic [IDX_W-1:0]  sel_idx;
    logic              push_fire, pop_fire;
    logic [CNT_W-1:0]  wr_pos;
    hdr_t              new_hdr, out_hdr;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live[i]    = (CNT_W'(i) < cnt_q);
            relaxed[i] = slot_q[i].ro;
            stuck[i]   = dst_full_i[slot_q[i].dst];
        end
    end

    generate
        for (genvar c = 0; c < NUM_TC; c++) begin : g_cls
            logic [DEPTH-1:0] member;
            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    member[i] = live[i] && (slot_q[i].tc == TC_W'(c));
                end
            end
            tco_class_pick #(.DEPTH(DEPTH)) u_pick (
                .member_i  (member),
                .relaxed_i (relaxed),
                .stuck_i   (stuck),
                .has_o     (cls_has[c]),
                .idx_o     (cls_idx[c])
            );
        end
    endgenerate

    tco_rr_arb #(.N(NUM_TC)) u_arb (
        .req_i       (cls_has),
        .ptr_i       (rr_q),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_cls)
    );

    assign sel_idx      = cls_idx[gnt_cls];
    assign out_hdr      = slot_q[sel_idx];
    assign pop_valid_o  = gnt_valid;
    assign pop_tc_o     = out_hdr.tc;
    assign pop_ro_o     = out_hdr.ro;
    assign pop_dst_o    = out_hdr.dst;
    assign pop_tag_o    = out_hdr.tag;
    assign push_ready_o = (cnt_q != CNT_W'(DEPTH));

    assign push_fire = push_valid_i && push_ready_o;
    assign pop_fire  = gnt_valid && pop_ready_i;
    assign wr_pos    = cnt_q - CNT_W'(pop_fire);

    always_comb begin
        new_hdr.tc  = push_tc_i;
        new_hdr.ro  = push_ro_i;
        new_hdr.dst = push_dst_i;
        new_hdr.tag = push_tag_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            rr_q  <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(push_fire) - CNT_W'(pop_fire);
            if (pop_fire) begin
                rr_q <= rr_after(gnt_cls);
            end
        end
    end

    // Removal closes the gap by shifting younger slots down one place.
    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop_fire && (IDX_W'(i) >= sel_idx)) begin
                slot_q[i] <= slot_q[i + 1];
            end
        end
        if (push_fire) begin
            slot_q[IDX_W'(wr_pos)] <= new_hdr;
        end
    end

endmodule

// File: rtl/tc_order_queue_chk.sv
module tc_order_queue_chk
    import tc_order_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             push_valid_i,
    input logic             push_ready_o,
    input logic             pop_valid_o,
    input logic             pop_ready_i,
    input logic [DST_W-1:0] pop_dst_o,
    input logic [NUM_DST-1:0] dst_full_i
);
    int occ;
    logic rst_d;

    always_ff @(posedge clk_i) begin
        rst_d <= rst_i;
        if (rst_i) begin
            occ <= 0;
        end else begin
            occ <= occ + int'(push_valid_i && push_ready_o) - int'(pop_valid_o && pop_ready_i);
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_d |-> (!pop_valid_o && push_ready_o));

    p_full_stall_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (occ == DEPTH) |-> !push_ready_o);

    p_room_ready_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (occ < DEPTH) |-> push_ready_o);

    p_dst_free_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_valid_o |-> !dst_full_i[pop_dst_o]);

    p_empty_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (occ == 0) |-> !pop_valid_o);

endmodule

bind tc_order_queue tc_order_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .push_valid_i (push_valid_i),
    .push_ready_o (push_ready_o),
    .pop_valid_o  (pop_valid_o),
    .pop_ready_i  (pop_ready_i),
    .pop_dst_o    (pop_dst_o),
    .dst_full_i   (dst_full_i)
);

// File: tb/tc_order_queue_tb_top.sv
`timescale 1ns/1ps
module tc_order_queue_tb_top;
    import tc_order_pkg::*;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             push_valid = 1'b0;
    logic [TC_W-1:0]  push_tc = '0;
    logic             push_ro = 1'b0;
    logic [DST_W-1:0] push_dst = '0;
    logic [TAG_W-1:0] push_tag = '0;
    logic             push_ready;
    logic             pop_valid;
    logic             pop_ready = 1'b0;
    logic [TC_W-1:0]  pop_tc;
    logic             pop_ro;
    logic [DST_W-1:0] pop_dst;
    logic [TAG_W-1:0] pop_tag;
    logic [NUM_DST-1:0] dst_full = '0;

    tc_order_queue #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .push_valid_i(push_valid), .push_tc_i(push_tc), .push_ro_i(push_ro),
        .push_dst_i(push_dst), .push_tag_i(push_tag), .push_ready_o(push_ready),
        .pop_valid_o(pop_valid), .pop_ready_i(pop_ready), .pop_tc_o(pop_tc),
        .pop_ro_o(pop_ro), .pop_dst_o(pop_dst), .pop_tag_o(pop_tag),
        .dst_full_i(dst_full)
    );

    typedef struct { int tc; bit ro; int dst; int tag; } m_hdr_t;
    m_hdr_t mq[$];
    int rr = 0;
    int checks = 0, fails = 0, pushed = 0, popped = 0;
    bit finished = 1'b0;
    bit obs_valid;
    int obs_tag, obs_tc;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of the issue decision, written from the requirements.
    task automatic model_pick(input logic [NUM_DST-1:0] full, output int idx, output int cls,
                              output bit byp, output int nel);
        int cand [NUM_TC];
        bit cbyp [NUM_TC];
        idx = -1; cls = -1; byp = 0; nel = 0;
        for (int c = 0; c < NUM_TC; c++) begin
            bit head_seen;
            head_seen = 0; cand[c] = -1; cbyp[c] = 0;
            foreach (mq[i]) begin
                if (cand[c] < 0 && mq[i].tc == c) begin
                    if (!head_seen) begin
                        head_seen = 1;
                        if (!full[mq[i].dst]) cand[c] = i;
                    end else if (mq[i].ro && !full[mq[i].dst]) begin
                        cand[c] = i; cbyp[c] = 1;
                    end
                end
            end
            if (cand[c] >= 0) nel++;
        end
        for (int k = 0; k < NUM_TC; k++) begin
            int c;
            c = (rr + k) % NUM_TC;
            if (idx < 0 && cand[c] >= 0) begin
                idx = cand[c]; cls = c; byp = cbyp[c];
            end
        end
    endtask

    task automatic step(input bit pv, input int tc, input bit ro, input int dst, input int tag,
                        input bit pr, input logic [NUM_DST-1:0] full);
        int idx, cls, nel;
        bit byp, pop_f, push_f;
        string req;
        @(negedge clk);
        push_valid = pv; push_tc = TC_W'(tc); push_ro = ro; push_dst = DST_W'(dst);
        push_tag = TAG_W'(tag); pop_ready = pr; dst_full = full;
        #1;
        model_pick(full, idx, cls, byp, nel);
        chk(push_ready == (mq.size() < DEPTH), "R2", "push_ready", int'(push_ready), int'(mq.size() < DEPTH));
        if (idx < 0) begin
            chk(!pop_valid, "R6", "pop_valid with nothing issuable", int'(pop_valid), 0);
        end else begin
            if (nel > 1) req = "R8";
            else if (byp) req = "R5";
            else if (mq[idx].ro) req = "R4";
            else req = "R3";
            chk(pop_valid == 1'b1, req, "pop_valid", int'(pop_valid), 1);
            chk(int'(pop_tag) == (mq[idx].tag & 8'hFF), req, "pop_tag", int'(pop_tag), mq[idx].tag & 8'hFF);
            chk(int'(pop_tc) == mq[idx].tc && int'(pop_dst) == mq[idx].dst && pop_ro == mq[idx].ro,
                req, "pop_tc", int'(pop_tc), mq[idx].tc);
        end
        obs_valid = pop_valid; obs_tag = int'(pop_tag); obs_tc = int'(pop_tc);
        pop_f  = pop_valid && pr;
        push_f = pv && push_ready;
        @(posedge clk);
        if (pop_f && idx >= 0) begin
            mq.delete(idx);
            rr = (cls + 1) % NUM_TC;
            popped++;
        end
        if (push_f) begin
            m_hdr_t h;
            h.tc = tc; h.ro = ro; h.dst = dst; h.tag = tag & 8'hFF;
            mq.push_back(h);
            pushed++;
        end
    endtask

    task automatic put(input int tc, input bit ro, input int dst, input int tag);
        step(1, tc, ro, dst, tag, 0, '0);
    endtask

    task automatic drain();
        for (int n = 0; n < 64 && mq.size() > 0; n++) step(0, 0, 0, 0, 0, 1, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4.0 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(!pop_valid, "R1", "pop_valid after reset", int'(pop_valid), 0);
        chk(push_ready, "R1", "push_ready after reset", int'(push_ready), 1);

        // R2: fill to DEPTH, check stall, then one pop reopens the push side.
        for (int i = 0; i < DEPTH; i++) put(i % 3, 0, 0, 100 + i);
        step(0, 0, 0, 0, 0, 0, '0);
        chk(!push_ready, "R2", "push_ready when full", int'(push_ready), 0);
        step(0, 0, 0, 0, 0, 1, '0);
        step(0, 0, 0, 0, 0, 0, '0);
        chk(push_ready, "R2", "push_ready after pop", int'(push_ready), 1);
        drain();

        // R7: class 2 blocked on dst0, class 6 free on dst1.
        put(2, 0, 0, 10);
        put(6, 0, 1, 20);
        step(0, 0, 0, 0, 0, 1, 4'b0001);
        chk(obs_valid && obs_tag == 20, "R7", "other class issues past stalled one", obs_tag, 20);
        drain();

        // R5 / R3 / R4: class 3 = A(plain,d0) B(plain,d1) C(ro,d0) D(ro,d2).
        put(3, 0, 0, 31);
        put(3, 0, 1, 32);
        put(3, 1, 0, 33);
        put(3, 1, 2, 34);
        step(0, 0, 0, 0, 0, 1, 4'b0001);
        chk(obs_valid && obs_tag == 34, "R5", "relaxed bypass of blocked head", obs_tag, 34);
        step(0, 0, 0, 0, 0, 1, 4'b0001);
        chk(!obs_valid, "R3", "plain header must not pass blocked head", int'(obs_valid), 0);
        step(0, 0, 0, 0, 0, 1, 4'b0000);
        chk(obs_valid && obs_tag == 31, "R4", "released head issues first", obs_tag, 31);
        step(0, 0, 0, 0, 0, 1, 4'b0000);
        chk(obs_valid && obs_tag == 32, "R3", "arrival order kept", obs_tag, 32);
        drain();

        // R4: free head issues even with relaxed headers behind it.
        put(5, 0, 1, 51);
        put(5, 1, 2, 52);
        step(0, 0, 0, 0, 0, 1, '0);
        chk(obs_valid && obs_tag == 51, "R4", "head preferred over relaxed", obs_tag, 51);
        drain();

        // R8: two classes alternate.
        put(1, 0, 0, 61);
        put(4, 0, 0, 62);
        put(1, 0, 0, 63);
        put(4, 0, 0, 64);
        step(0, 0, 0, 0, 0, 1, '0);
        begin
            int first_tc;
            first_tc = obs_tc;
            step(0, 0, 0, 0, 0, 1, '0);
            chk(obs_valid && obs_tc != first_tc, "R8", "grant rotates between classes", obs_tc, first_tc ^ 5);
        end
        drain();

        // Random phase: destination mask held for 8 cycles at a time.
        begin
            logic [NUM_DST-1:0] full;
            full = '0;
            for (int n = 0; n < 3000; n++) begin
                if (n % 8 == 0) full = NUM_DST'($urandom & $urandom);
                step(($urandom % 3) != 0, int'($urandom % NUM_TC), bit'($urandom % 2),
                     int'($urandom % NUM_DST), n, ($urandom % 4) != 0, full);
            end
        end
        drain();
        step(0, 0, 0, 0, 0, 1, '0);
        chk(mq.size() == 0 && pushed == popped, "R9", "all pushed headers popped", popped, pushed);
        chk(!obs_valid, "R9", "idle after drain", int'(obs_valid), 0);

        finish_run();
    end

endmodule